// File: doc/BRIEF.md
# Inbound Doorbell Queue Controller

This block takes doorbell packets that have already been received from the link. Each packet carries a source ID, a target ID and a 16-bit info word. The block turns each packet into an 8-byte record and writes it through a single write port into a circular queue held in memory. The block keeps the enqueue pointer and the dequeue pointer and works out from them whether the queue is empty or full. Software sees a small register file: a mode word, a status word with write-1-to-clear bits, and the two pointers.

Software reads the record at the dequeue pointer. It then writes the mode register with the advance command bit set, and the dequeue pointer steps forward by one record. A size code in the mode register sets the ring length to a power of two entries, up to a 4 KB ring. A doorbell that arrives while the ring is full is dropped and flagged. The interrupt output stays active while any enabled status condition is pending. Register indices on the 2-bit index port: 0 mode, 1 status, 2 dequeue pointer, 3 enqueue pointer.

Top module: `db_inq_ctrl`

## Requirements
- R1: After reset, all four registers read zero, irq_o is low and mem_we_o is low.
- R2: An accepted doorbell causes one mem_we_o pulse on the cycle after it is presented. The address is the enqueue pointer and the data word is {16'h0000, target, source, info} from bit 63 down to bit 0.
- R3: The mode register is at index 0. Its fields are enable at bit 0, advance command at bit 1, size code at bits 15:12, error interrupt enable at bit 5, pending interrupt enable at bit 6, full interrupt enable at bit 8 and snoop at bit 20. Each accepted doorbell moves the enqueue pointer 8 bytes forward. The ring is 8*2^(code+1) bytes long, and codes above 8 act as 8. At the end of the ring the offset bits inside the ring wrap to zero, and all address bits above the ring are kept.
- R4: Writing mode with bit 1 set moves the dequeue pointer 8 bytes forward, with the same wrap rule. The command is ignored when the queue is empty. Bit 1 always reads back 0.
- R5: The queue is full when 2^(code+1) entries are outstanding. A doorbell that arrives while the queue is full produces no memory write, leaves the enqueue pointer unchanged and sets status bit 4.
- R6: While enable is 0, doorbells and error pulses are ignored.
- R7: Status is at index 1. Bit 7 is error, bit 4 is full and bit 0 is pending. Writing 1 to a bit clears it. A set event in the same cycle as a clear wins over the clear.
- R8: The pending bit is set by every accepted doorbell. After a clear, it sets again on the next cycle if the queue is not empty. It stays clear if the queue is empty.
- R9: A pulse on db_err_i while the block is enabled sets status bit 7.
- R10: irq_o = (pending & mode[6]) | (full & mode[8]) | (error & mode[5]).
- R11: Writing index 2 (dequeue) or index 3 (enqueue) loads that pointer with bits 2:0 forced to zero. The write also resets lap tracking, so equal pointers then mean an empty queue.
- R12: mem_snoop_o follows mode bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| db_valid_i | input | 1 | Doorbell present this cycle |
| db_src_i | input | 16 | Source ID |
| db_tgt_i | input | 16 | Target ID |
| db_info_i | input | 16 | Info word |
| db_err_i | input | 1 | Reception error pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i |
| mem_we_o | output | 1 | Record write strobe |
| mem_addr_o | output | 32 | Record byte address |
| mem_wdata_o | output | 64 | Record data |
| mem_snoop_o | output | 1 | Snoop attribute for record writes |
| irq_o | output | 1 | Interrupt |

## Verification
The embedded assertions check on every cycle the rules that link one cycle to the next. A record write follows exactly the cycles with an accepted doorbell. The enqueue pointer holds when nothing moves it, and an advance command on an empty queue does not move the dequeue pointer. A queue that is not empty re-asserts the pending bit, and a cleared error bit stays clear when no new error arrives. The bench scenarios cover what depends on values across many cycles: the record layout, the wrap address in a short ring whose base sits above the ring span, the drop when the ring is full, the effect of reloading a pointer on lap tracking, and the way interrupt enables combine with status.

// File: rtl/db_inq_pkg.sv
package db_inq_pkg;
  localparam logic [1:0] IDX_MODE = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_DQ   = 2'd2;
  localparam logic [1:0] IDX_EQ   = 2'd3;

  localparam int M_EN      = 0;
  localparam int M_ADV     = 1;
  localparam int M_IE_ERR  = 5;
  localparam int M_IE_PEND = 6;
  localparam int M_IE_FULL = 8;
  localparam int M_SZ_LSB  = 12;
  localparam int M_SZ_W    = 4;
  localparam int M_SNOOP   = 20;

  localparam int S_PEND = 0;
  localparam int S_FULL = 4;
  localparam int S_ERR  = 7;

  localparam logic [31:0] MODE_WMASK =
      (32'h1 << M_EN) | (32'h1 << M_IE_ERR) | (32'h1 << M_IE_PEND) |
      (32'h1 << M_IE_FULL) | (32'hF << M_SZ_LSB) | (32'h1 << M_SNOOP);

  typedef struct packed {
    logic [15:0] pad;
    logic [15:0] tgt;
    logic [15:0] src;
    logic [15:0] info;
  } rec_t;
endpackage

// File: rtl/db_inq_ptrs.sv
module db_inq_ptrs #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int SZ_W     = 4,
  parameter int MAX_CODE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SZ_W-1:0]   size_code_i,
  input  logic              enq_i,
  input  logic              adv_cmd_i,
  input  logic              dq_wr_i,
  input  logic              eq_wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] eq_o,
  output logic [ADDR_W-1:0] dq_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [ADDR_W-1:0] eq_q, dq_q, eq_nxt, dq_nxt, wr_val;
  logic              eq_lap_q, dq_lap_q;
  logic [SZ_W-1:0]   code_eff;
  logic [OFF_W:0]    span;
  logic [OFF_W-1:0]  mask, eq_off, dq_off, last_off;
  logic              eq_at_end, dq_at_end, deq_go, ptr_wr;

  always_comb begin
    code_eff  = (int'(size_code_i) > MAX_CODE) ? SZ_W'(MAX_CODE) : size_code_i;
    span      = (OFF_W+1)'(8) << (int'(code_eff) + 1);
    mask      = OFF_W'(span - (OFF_W+1)'(1));
    last_off  = mask & ~OFF_W'(7);
    eq_off    = eq_q[OFF_W-1:0] & mask;
    dq_off    = dq_q[OFF_W-1:0] & mask;
    eq_at_end = (eq_off == last_off);
    dq_at_end = (dq_off == last_off);
    // bits above the ring span are kept on wrap
    eq_nxt = {eq_q[ADDR_W-1:OFF_W],
              (eq_q[OFF_W-1:0] & ~mask) | ((eq_q[OFF_W-1:0] + OFF_W'(8)) & mask)};
    dq_nxt = {dq_q[ADDR_W-1:OFF_W],
              (dq_q[OFF_W-1:0] & ~mask) | ((dq_q[OFF_W-1:0] + OFF_W'(8)) & mask)};
    wr_val = wdata_i & ~ADDR_W'(7);
  end

  assign empty_o = (eq_off == dq_off) && (eq_lap_q == dq_lap_q);
  assign full_o  = (eq_off == dq_off) && (eq_lap_q != dq_lap_q);
  assign deq_go  = adv_cmd_i && !empty_o;
  assign ptr_wr  = eq_wr_i || dq_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q     <= '0;
      dq_q     <= '0;
      eq_lap_q <= 1'b0;
      dq_lap_q <= 1'b0;
    end else if (ptr_wr) begin
      if (eq_wr_i) eq_q <= wr_val;
      if (dq_wr_i) dq_q <= wr_val;
      eq_lap_q <= 1'b0;
      dq_lap_q <= 1'b0;
    end else begin
      if (enq_i) begin
        eq_q <= eq_nxt;
        if (eq_at_end) eq_lap_q <= ~eq_lap_q;
      end
      if (deq_go) begin
        dq_q <= dq_nxt;
        if (dq_at_end) dq_lap_q <= ~dq_lap_q;
      end
    end
  end

  assign eq_o = eq_q;
  assign dq_o = dq_q;

  // R3
  eq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enq_i && !eq_wr_i) |=> $stable(eq_q));
  // R4
  adv_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_cmd_i && empty_o && !ptr_wr) |=> $stable(dq_q));
  // R5
  enq_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && !ptr_wr) |=> (!empty_o || !$stable(size_code_i)));
endmodule

// File: rtl/db_inq_writer.sv
module db_inq_writer
  import db_inq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       src_i,
  input  logic [15:0]       tgt_i,
  input  logic [15:0]       info_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o
);
  rec_t rec;

  always_comb begin
    rec.pad  = 16'h0000;
    rec.tgt  = tgt_i;
    rec.src  = src_i;
    rec.info = info_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= enq_i;
      if (enq_i) begin
        mem_addr_o  <= addr_i;
        mem_wdata_o <= rec;
      end
    end
  end

  // R2
  wr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |=> mem_we_o);
  // R2
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enq_i |=> !mem_we_o);
endmodule

// File: rtl/db_inq_regs.sv
module db_inq_regs
  import db_inq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_idx_i,
  input  logic [31:0] wdata_i,
  input  logic        enq_i,
  input  logic        drop_i,
  input  logic        err_i,
  input  logic        empty_i,
  output logic [31:0] mode_o,
  output logic [31:0] stat_o,
  output logic        adv_cmd_o,
  output logic        irq_o
);
  logic [31:0] mode_q;
  logic        pend_q, full_q, err_q;
  logic        stat_we, clr_pend, clr_full, clr_err;

  assign stat_we   = reg_we_i && (reg_idx_i == IDX_STAT);
  assign clr_pend  = stat_we && wdata_i[S_PEND];
  assign clr_full  = stat_we && wdata_i[S_FULL];
  assign clr_err   = stat_we && wdata_i[S_ERR];
  assign adv_cmd_o = reg_we_i && (reg_idx_i == IDX_MODE) && wdata_i[M_ADV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pend_q <= 1'b0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (reg_we_i && (reg_idx_i == IDX_MODE)) mode_q <= wdata_i & MODE_WMASK;
      // set wins over clear; pending re-arms while entries remain
      pend_q <= enq_i  || ((pend_q || !empty_i) && !clr_pend);
      full_q <= drop_i || (full_q && !clr_full);
      err_q  <= err_i  || (err_q && !clr_err);
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[S_PEND] = pend_q;
    stat_o[S_FULL] = full_q;
    stat_o[S_ERR]  = err_q;
  end

  assign mode_o = mode_q;
  assign irq_o  = (pend_q & mode_q[M_IE_PEND]) | (full_q & mode_q[M_IE_FULL]) |
                  (err_q & mode_q[M_IE_ERR]);

  // R8
  pend_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_i && !clr_pend) |=> stat_o[S_PEND]);
  // R7
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err && !err_i) |=> !stat_o[S_ERR]);
  // R7
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[S_FULL] && !clr_full) |=> stat_o[S_FULL]);
endmodule

// File: rtl/db_inq_ctrl.sv
module db_inq_ctrl
  import db_inq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RING_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              db_valid_i,
  input  logic [15:0]       db_src_i,
  input  logic [15:0]       db_tgt_i,
  input  logic [15:0]       db_info_i,
  input  logic              db_err_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  output logic              mem_snoop_o,
  output logic              irq_o
);
  localparam int OFF_W    = $clog2(RING_BYTES);
  localparam int MAX_CODE = $clog2(RING_BYTES / 8) - 1;

  logic [31:0]       mode, stat;
  logic [ADDR_W-1:0] eq_ptr, dq_ptr;
  logic              empty, full, adv_cmd, eq_wr, dq_wr, ptr_wr;
  logic              enabled, accept, drop, err_acc;

  assign enabled = mode[M_EN];
  assign eq_wr   = reg_we_i && (reg_idx_i == IDX_EQ);
  assign dq_wr   = reg_we_i && (reg_idx_i == IDX_DQ);
  assign ptr_wr  = eq_wr || dq_wr;
  assign accept  = db_valid_i && enabled && !full && !ptr_wr;
  assign drop    = db_valid_i && enabled && full && !ptr_wr;
  assign err_acc = db_err_i && enabled;

  db_inq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reg_we_i  (reg_we_i),
    .reg_idx_i (reg_idx_i),
    .wdata_i   (reg_wdata_i),
    .enq_i     (accept),
    .drop_i    (drop),
    .err_i     (err_acc),
    .empty_i   (empty),
    .mode_o    (mode),
    .stat_o    (stat),
    .adv_cmd_o (adv_cmd),
    .irq_o     (irq_o)
  );

  db_inq_ptrs #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .SZ_W     (M_SZ_W),
    .MAX_CODE (MAX_CODE)
  ) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_code_i (mode[M_SZ_LSB +: M_SZ_W]),
    .enq_i       (accept),
    .adv_cmd_i   (adv_cmd),
    .dq_wr_i     (dq_wr),
    .eq_wr_i     (eq_wr),
    .wdata_i     (reg_wdata_i[ADDR_W-1:0]),
    .eq_o        (eq_ptr),
    .dq_o        (dq_ptr),
    .empty_o     (empty),
    .full_o      (full)
  );

  db_inq_writer #(
    .ADDR_W (ADDR_W)
  ) u_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_i       (accept),
    .addr_i      (eq_ptr),
    .src_i       (db_src_i),
    .tgt_i       (db_tgt_i),
    .info_i      (db_info_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign mem_snoop_o = mode[M_SNOOP];

  always_comb begin
    case (reg_idx_i)
      IDX_MODE: reg_rdata_o = mode;
      IDX_STAT: reg_rdata_o = stat;
      IDX_DQ:   reg_rdata_o = 32'(dq_ptr);
      default:  reg_rdata_o = 32'(eq_ptr);
    endcase
  end

  // R5
  drop_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> !mem_we_o);
  // R6
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enabled && !ptr_wr) |=> $stable(eq_ptr));
endmodule

// File: tb/tb_db_inq_ctrl.sv
module tb_db_inq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        db_valid = 1'b0, db_err = 1'b0;
  logic [15:0] db_src = '0, db_tgt = '0, db_info = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we, mem_snoop, irq;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  db_inq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .db_valid_i(db_valid), .db_src_i(db_src), .db_tgt_i(db_tgt),
    .db_info_i(db_info), .db_err_i(db_err),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_snoop_o(mem_snoop), .irq_o(irq)
  );

  // {src, tgt, info, expected byte offset from base}
  localparam logic [63:0] VEC [4] = '{
    64'h0011_0022_1234_0000,
    64'hABCD_0001_FFFF_0008,
    64'h0000_FFFF_0000_0010,
    64'h7E7E_8181_5A5A_0018
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] d);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic send_db(input logic [15:0] s, input logic [15:0] t, input logic [15:0] i);
    db_valid = 1'b1; db_src = s; db_tgt = t; db_info = i;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic pulse_err();
    db_err = 1'b1;
    @(negedge clk);
    db_err = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      rd_reg(2'(k), v);
      check("R1 reg", 64'(v), 64'h0);
    end
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 we", 64'(mem_we), 64'h0);

    // R6 doorbell ignored while disabled
    send_db(16'h1, 16'h2, 16'h3);
    check("R6 no write", 64'(mem_we), 64'h0);
    rd_reg(2'd3, v);
    check("R6 eq", 64'(v), 64'h0);

    // R11 pointer load, low bits forced to zero
    wr_reg(2'd2, 32'h2000_0000);
    wr_reg(2'd3, 32'h2000_0005);
    rd_reg(2'd3, v);
    check("R11 eq align", 64'(v), 64'h2000_0000);
    wr_reg(2'd1, 32'h91);
    wr_reg(2'd0, 32'h0010_8041);
    rd_reg(2'd0, v);
    check("R3 mode", 64'(v), 64'h0010_8041);
    check("R12 snoop", 64'(mem_snoop), 64'h1);

    // R2 record layout and address, table driven
    for (int k = 0; k < 4; k++) begin
      send_db(VEC[k][63:48], VEC[k][47:32], VEC[k][31:16]);
      check("R2 we", 64'(mem_we), 64'h1);
      check("R2 addr", 64'(mem_addr), 64'h2000_0000 + 64'(VEC[k][15:0]));
      check("R2 data", mem_wdata, {16'h0, VEC[k][47:32], VEC[k][63:48], VEC[k][31:16]});
    end
    rd_reg(2'd3, v);
    check("R3 eq step", 64'(v), 64'h2000_0020);
    rd_reg(2'd1, v);
    check("R8 pend set", 64'(v), 64'h1);
    check("R10 irq pend", 64'(irq), 64'h1);

    // R4 advance command
    wr_reg(2'd0, 32'h0010_8043);
    rd_reg(2'd2, v);
    check("R4 dq step", 64'(v), 64'h2000_0008);
    rd_reg(2'd0, v);
    check("R4 adv reads 0", 64'(v), 64'h0010_8041);

    // R7 clear, R8 re-arm while not empty
    wr_reg(2'd1, 32'h1);
    rd_reg(2'd1, v);
    check("R7 pend cleared", 64'(v), 64'h0);
    @(negedge clk);
    rd_reg(2'd1, v);
    check("R8 pend rearm", 64'(v), 64'h1);

    // R10 enable gating
    wr_reg(2'd0, 32'h0010_8001);
    check("R10 irq masked", 64'(irq), 64'h0);

    // drain, then advance on empty
    for (int k = 0; k < 3; k++) wr_reg(2'd0, 32'h0010_8003);
    rd_reg(2'd2, v);
    check("R4 drained", 64'(v), 64'h2000_0020);
    wr_reg(2'd0, 32'h0010_8003);
    rd_reg(2'd2, v);
    check("R4 empty ignore", 64'(v), 64'h2000_0020);
    wr_reg(2'd1, 32'h91);
    @(negedge clk);
    rd_reg(2'd1, v);
    check("R8 empty stays clear", 64'(v), 64'h0);

    // R5 full on a 4-entry ring whose base sits above the ring span
    wr_reg(2'd0, 32'h0000_1101);
    wr_reg(2'd2, 32'h3000_0040);
    wr_reg(2'd3, 32'h3000_0040);
    wr_reg(2'd1, 32'h91);
    for (int k = 0; k < 4; k++) begin
      send_db(16'(k), 16'h9, 16'h8);
      check("R3 small ring addr", 64'(mem_addr), 64'h3000_0040 + 64'(8 * k));
    end
    rd_reg(2'd3, v);
    check("R3 wrap keeps upper", 64'(v), 64'h3000_0040);
    check("R10 irq full off", 64'(irq), 64'h0);
    send_db(16'h5, 16'h5, 16'h5);
    check("R5 drop no write", 64'(mem_we), 64'h0);
    rd_reg(2'd3, v);
    check("R5 eq held", 64'(v), 64'h3000_0040);
    rd_reg(2'd1, v);
    check("R5 full flag", 64'(v[4]), 64'h1);
    check("R10 irq full", 64'(irq), 64'h1);

    // R11 reload resets lap tracking
    wr_reg(2'd3, 32'h3000_0040);
    wr_reg(2'd0, 32'h0000_1103);
    rd_reg(2'd2, v);
    check("R11 empty after load", 64'(v), 64'h3000_0040);
    send_db(16'h6, 16'h6, 16'h6);
    check("R11 accept", 64'(mem_we), 64'h1);
    check("R11 addr", 64'(mem_addr), 64'h3000_0040);

    // R9 error bit and R7 priority
    wr_reg(2'd2, 32'h0);
    wr_reg(2'd3, 32'h0);
    wr_reg(2'd0, 32'h21);
    wr_reg(2'd1, 32'h91);
    pulse_err();
    rd_reg(2'd1, v);
    check("R9 err set", 64'(v), 64'h80);
    check("R10 irq err", 64'(irq), 64'h1);
    wr_reg(2'd1, 32'h80);
    rd_reg(2'd1, v);
    check("R7 err clear", 64'(v), 64'h0);
    db_err = 1'b1;
    wr_reg(2'd1, 32'h80);
    db_err = 1'b0;
    rd_reg(2'd1, v);
    check("R7 set wins", 64'(v), 64'h80);

    // R6 error ignored while disabled
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h91);
    pulse_err();
    rd_reg(2'd1, v);
    check("R6 err ignored", 64'(v), 64'h0);
    check("R12 snoop off", 64'(mem_snoop), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule